// File: doc/BRIEF.md
# Double-Buffered Frame Capture Memory

This block sits behind a camera receiver and stores the incoming pixel stream in on-chip memory with no processor or DMA help. The stream brings a pixel word, a valid strobe, a start-of-frame flag and an end-of-line flag. Each pixel is written to its own location, so a whole image lies in a flat array with one host address per pixel.

Two banks are held. The camera fills one bank while the host reads the other, which holds the last complete frame. When a frame closes with the right pixel count, the bank roles swap by flipping a single index bit. No pixel is ever copied, and the host never sees a frame that is still being written. The host side is a plain read port with fixed latency and its own memory path, so capture traffic never steals host cycles. A one-cycle ready pulse and a frame sequence number mark each new frame. A sticky error flag reports frames that were thrown away.

Frame size is set at build time (`IMG_W` pixels per line, `IMG_H` lines). Both sides run on one clock.

Top module: `frame_capture_dbuf`

## Requirements
- R1: A beat is accepted when `px_valid` is high and either `px_sof` is high or a frame is open. A beat with `px_sof` high starts a frame and is stored at address 0. Each later accepted beat is stored at the next address. After a frame is published, host address a returns the a-th accepted pixel of that frame.
- R2: `rd_data` shows the word for the `rd_addr` sampled at the previous rising clock edge (read latency of one cycle).
- R3: A host read at an address of `IMG_W*IMG_H` or above returns zero.
- R4: A frame closes on the accepted beat that carries the `IMG_H`-th end-of-line flag since its start. If exactly `IMG_W*IMG_H` pixels were accepted by then, the frame is published and the host side switches to the bank that holds it. Lines of unequal length still count when the total is right.
- R5: When a frame is published, `frame_ready` is high for one cycle. In that same cycle `frame_seq` is one higher than before. At all other times `frame_seq` holds its value.
- R6: A frame is dropped if it closes with too few or too many pixels, or if a new start-of-frame arrives while it is still open. A dropped frame leaves the host contents unchanged and sets `frame_err`. `frame_err` stays high until the next frame is published.
- R7: While the next frame is being captured, the published frame is never changed. If the read address does not change and no publish happens, `rd_data` stays the same.
- R8: After reset, `frame_ready`, `frame_seq`, `frame_err`, `have_frame` and `rd_data` are all zero.
- R9: Beats with `px_valid` low are ignored, whatever their flags say. Valid beats that arrive while no frame is open and that carry no start-of-frame flag are also ignored.
- R10: `have_frame` goes high with the first published frame and stays high. `frame_seq` wraps modulo 2^`SEQ_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by capture and host sides |
| rst_n | input | 1 | Synchronous active-low reset |
| px_valid | input | 1 | Pixel strobe for the current beat |
| px_data | input | PIX_W | Pixel value |
| px_sof | input | 1 | First pixel of a frame (counts only when px_valid is high) |
| px_eol | input | 1 | Last pixel of a line (counts only when px_valid is high) |
| rd_addr | input | ADDR_W | Host pixel address |
| rd_data | output | PIX_W | Host read data, one cycle after the address |
| frame_ready | output | 1 | One-cycle pulse when a new frame is published |
| frame_seq | output | SEQ_W | Count of published frames |
| frame_err | output | 1 | Sticky flag for a dropped frame |
| have_frame | output | 1 | At least one frame has been published |

## Verification
The bench targets the frame boundary cases:
- Frames that are one pixel short per line or one pixel long per line. A design that counted lines but not pixels would publish these frames and expose garbage.
- A frame whose line lengths are uneven but whose total is correct. A design that checked each line would wrongly drop it.
- A frame cut short by a new start-of-frame. A design that ignored this would mix two images.

Throughout, the host address sweeps continuously, including addresses past the end. Each read is compared with a model of the published frame. A design that wrote into the host bank, swapped too early, or leaked stale words for out-of-range addresses would show torn or wrong data. The idle beats carry asserted start and end flags with the strobe low, so a design that trusted the flags without the strobe would restart its frames. A run of more than 256 frames drives the sequence counter through its wrap.

// File: rtl/fcap_pkg.sv
// Shared types for the double-buffered frame capture block.
// Assumes a single clock domain for capture and host sides.
package fcap_pkg;

    // Capture state: waiting for a start-of-frame, or inside a frame
    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_OPEN = 1'b1
    } cap_state_e;

    // Frame close outcome raised by the write controller for one cycle
    typedef struct packed {
        logic good;   // frame closed with exactly the expected pixel count
        logic bad;    // frame dropped: wrong count or aborted by a new start
    } frame_evt_t;

endpackage

// File: rtl/fcap_wr_ctrl.sv
// Write-side controller: turns the stream flags into a write address and
// a write enable, counts lines, and judges each frame when it closes.
// Assumes px flags are only meaningful when valid is high. Pixels past
// the frame size are not written; the count saturates at N+1.
module fcap_wr_ctrl
    import fcap_pkg::*;
#(
    parameter int IMG_W  = 8,
    parameter int IMG_H  = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eol,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output frame_evt_t        evt
);

    localparam int N_PIX = IMG_W * IMG_H;
    localparam int CNT_W = $clog2(N_PIX + 3);
    localparam int LN_W  = $clog2(IMG_H + 1);

    cap_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LN_W-1:0]  lines_q;

    logic             accept;
    logic             abort;
    logic             closing;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] seen;
    logic [LN_W-1:0]  line_base;
    logic [LN_W-1:0]  line_next;

    // Decode the current beat: acceptance, address, close and verdict
    always_comb begin
        accept    = in_valid && (in_sof || state_q == CAP_OPEN);
        abort     = in_valid && in_sof && state_q == CAP_OPEN;
        pos       = in_sof ? '0 : cnt_q;
        seen      = pos + 1'b1;
        line_base = in_sof ? '0 : lines_q;
        line_next = line_base + 1'b1;
        closing   = accept && in_eol && (line_next == LN_W'(IMG_H));
        wr_en     = accept && (pos < CNT_W'(N_PIX));
        wr_addr   = ADDR_W'(pos);
        evt.good  = closing && (seen == CNT_W'(N_PIX));
        evt.bad   = abort || (closing && (seen != CNT_W'(N_PIX)));
    end

    // Track frame state, saturating pixel count and line count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            cnt_q   <= '0;
            lines_q <= '0;
        end else if (accept) begin
            state_q <= closing ? CAP_IDLE : CAP_OPEN;
            cnt_q   <= (seen > CNT_W'(N_PIX)) ? CNT_W'(N_PIX + 1) : seen;
            lines_q <= in_eol ? line_next : line_base;
        end
    end

endmodule

// File: rtl/fcap_bank_sel.sv
// Bank role keeper: holds the index of the bank the host reads, flips it
// when a good frame closes, and keeps the ready pulse, sequence count,
// sticky error and have-frame status. The fill bank is the other index.
module fcap_bank_sel
    import fcap_pkg::*;
#(
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  frame_evt_t       evt,
    output logic             host_idx,
    output logic             frame_ready,
    output logic [SEQ_W-1:0] frame_seq,
    output logic             frame_err,
    output logic             have_frame
);

    // Swap bank roles and update status on a frame verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_idx    <= 1'b0;
            frame_ready <= 1'b0;
            frame_seq   <= '0;
            frame_err   <= 1'b0;
            have_frame  <= 1'b0;
        end else begin
            frame_ready <= evt.good;
            if (evt.good) begin
                host_idx   <= ~host_idx;
                frame_seq  <= frame_seq + 1'b1;
                have_frame <= 1'b1;
            end
            if (evt.bad) begin
                frame_err <= 1'b1;
            end else if (evt.good) begin
                frame_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fcap_bank_mem.sv
// Two frame banks, each with its own write and read path. The capture
// side writes one bank; the host reads the selected bank through a
// registered port. Out-of-range host addresses return zero.
module fcap_bank_mem #(
    parameter int PIX_W  = 8,
    parameter int N_PIX  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PIX_W-1:0]  wr_data,
    input  logic              rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PIX_W-1:0]  rd_data
);

    localparam int IDX_W = (N_PIX > 1) ? $clog2(N_PIX) : 1;

    logic [PIX_W-1:0] bank_word [2];
    logic             in_range;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [PIX_W-1:0] cells [N_PIX];

        // Store a captured pixel when this bank is the fill bank
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(g))) begin
                cells[IDX_W'(wr_addr)] <= wr_data;
            end
        end

        assign bank_word[g] = cells[IDX_W'(rd_addr)];
    end

    assign in_range = (rd_addr < ADDR_W'(N_PIX));

    // Register the host word from the published bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= in_range ? bank_word[rd_bank] : '0;
        end
    end

endmodule

// File: rtl/frame_capture_dbuf.sv
// Top: double-buffered frame capture memory. The pixel stream is written
// into the fill bank; the host reads the last complete frame from the
// other bank. Roles swap by an index flip, never by copying.
// Assumes one clock for both sides and a fixed IMG_W x IMG_H frame.
module frame_capture_dbuf
    import fcap_pkg::*;
#(
    parameter  int PIX_W  = 8,
    parameter  int IMG_W  = 8,
    parameter  int IMG_H  = 4,
    parameter  int SEQ_W  = 8,
    localparam int N_PIX  = IMG_W * IMG_H,
    localparam int ADDR_W = $clog2(N_PIX) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              px_valid,
    input  logic [PIX_W-1:0]  px_data,
    input  logic              px_sof,
    input  logic              px_eol,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PIX_W-1:0]  rd_data,
    output logic              frame_ready,
    output logic [SEQ_W-1:0]  frame_seq,
    output logic              frame_err,
    output logic              have_frame
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    frame_evt_t        evt;
    logic              host_idx;
    logic              wr_bank;

    assign wr_bank = ~host_idx;

    fcap_wr_ctrl #(
        .IMG_W  (IMG_W),
        .IMG_H  (IMG_H),
        .ADDR_W (ADDR_W)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (px_valid),
        .in_sof   (px_sof),
        .in_eol   (px_eol),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .evt      (evt)
    );

    fcap_bank_sel #(
        .SEQ_W (SEQ_W)
    ) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .host_idx    (host_idx),
        .frame_ready (frame_ready),
        .frame_seq   (frame_seq),
        .frame_err   (frame_err),
        .have_frame  (have_frame)
    );

    fcap_bank_mem #(
        .PIX_W  (PIX_W),
        .N_PIX  (N_PIX),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (px_data),
        .rd_bank (host_idx),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/fcap_chk.sv
// Property checker for frame_capture_dbuf, attached with bind.
// Watches only the top-level ports.
module fcap_chk #(
    parameter int PIX_W  = 8,
    parameter int N_PIX  = 32,
    parameter int ADDR_W = 6,
    parameter int SEQ_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [PIX_W-1:0]  rd_data,
    input logic              frame_ready,
    input logic [SEQ_W-1:0]  frame_seq,
    input logic              frame_err,
    input logic              have_frame
);

    logic [1:0] warm_q;

    // Count edges since reset so two-deep history is valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R5
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |-> (frame_seq == SEQ_W'($past(frame_seq) + 1'b1)));

    // R5
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ready |-> $stable(frame_seq));

    // R3
    oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_addr) >= ADDR_W'(N_PIX)) |-> (rd_data == '0));

    // R6
    ready_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |-> !frame_err);

    // R10
    ready_have_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |-> have_frame);

    // R10
    have_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(have_frame) |-> have_frame);

    // R7
    no_tear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && $past(rd_addr) == $past(rd_addr, 2) && !$past(frame_ready))
            |-> $stable(rd_data));

endmodule

bind frame_capture_dbuf fcap_chk #(
    .PIX_W  (PIX_W),
    .N_PIX  (N_PIX),
    .ADDR_W (ADDR_W),
    .SEQ_W  (SEQ_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .frame_ready (frame_ready),
    .frame_seq   (frame_seq),
    .frame_err   (frame_err),
    .have_frame  (have_frame)
);

// File: tb/tb_frame_capture_dbuf.sv
// Bench: behavioural reference model (queues, counters) compared with
// the design on every falling edge; stimulus covers good, short, long,
// aborted and irregular frames plus a sequence-counter wrap.
module tb_frame_capture_dbuf;

    localparam int CLK_PERIOD = 10;
    localparam int W     = 8;
    localparam int H     = 4;
    localparam int N     = W * H;
    localparam int AW    = $clog2(N) + 1;
    localparam int PW    = 8;
    localparam int SW    = 8;
    localparam int LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          px_valid = 1'b0;
    logic [PW-1:0] px_data = '0;
    logic          px_sof = 1'b0;
    logic          px_eol = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [PW-1:0] rd_data;
    logic          frame_ready;
    logic [SW-1:0] frame_seq;
    logic          frame_err;
    logic          have_frame;

    int n_chk = 0;
    int n_bad = 0;
    int n_good_sent = 0;
    int cycles = 0;

    frame_capture_dbuf #(.PIX_W(PW), .IMG_W(W), .IMG_H(H), .SEQ_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_data(px_data),
        .px_sof(px_sof), .px_eol(px_eol), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_ready(frame_ready), .frame_seq(frame_seq), .frame_err(frame_err),
        .have_frame(have_frame)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model state
    logic [PW-1:0] m_bank [2][N];
    logic [PW-1:0] m_q [$];
    int   m_host = 0;
    int   m_seq  = 0;
    bit   m_err  = 0;
    bit   m_have = 0;
    bit   m_open = 0;
    int   m_lines = 0;
    bit   e_ready = 0;
    int   e_rd = 0;
    bit   e_rd_chk = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model: predict outputs for the next cycle from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_host = 0; m_seq = 0; m_err = 0; m_have = 0; m_open = 0;
            m_lines = 0; e_ready = 0; e_rd = 0; e_rd_chk = 1; m_q.delete();
        end else begin
            bit dropped, good;
            dropped = 0; good = 0;
            e_rd_chk = (int'(rd_addr) >= N) || m_have;
            e_rd = (int'(rd_addr) < N) ? int'(m_bank[m_host][int'(rd_addr)]) : 0;
            if (px_valid) begin
                if (px_sof) begin
                    if (m_open) dropped = 1;
                    m_q.delete();
                    m_open = 1;
                    m_lines = 0;
                end
                if (m_open) begin
                    m_q.push_back(px_data);
                    if (px_eol) begin
                        m_lines++;
                        if (m_lines == H) begin
                            m_open = 0;
                            if (m_q.size() == N) good = 1; else dropped = 1;
                        end
                    end
                end
            end
            e_ready = good;
            if (good) begin
                for (int i = 0; i < N; i++) m_bank[1 - m_host][i] = m_q[i];
                m_host = 1 - m_host;
                m_seq = (m_seq + 1) % (1 << SW);
                m_have = 1;
            end
            if (dropped) m_err = 1;
            else if (good) m_err = 0;
        end
    end

    // Compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 R5 frame_ready", frame_ready, e_ready);
            chk("R5 R10 frame_seq", frame_seq, m_seq);
            chk("R6 frame_err", frame_err, m_err);
            chk("R10 have_frame", have_frame, m_have);
            if (e_rd_chk) chk("R1 R2 R3 R7 rd_data", rd_data, e_rd);
        end
    end

    // Host address sweep, including out-of-range addresses
    always @(negedge clk) rd_addr <= rd_addr + AW'(7);

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1 run hung actual=%0d expected<%0d", cycles, LIMIT);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic put(input logic v, input logic s, input logic e, input logic [PW-1:0] d);
        px_valid = v; px_sof = s; px_eol = e; px_data = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 1'b0, 1'b0, '0);
    endtask

    // One line; optional strobe-low beats with flags set (R9)
    task automatic send_line(input int n, input bit first, input int seed, input bit gaps);
        for (int k = 0; k < n; k++) begin
            put(1'b1, first && k == 0, k == n - 1, PW'(seed + k * 13));
            if (gaps && (k % 3 == 1)) put(1'b0, 1'b1, 1'b1, 8'hA5);
        end
    endtask

    task automatic send_frame(input int per_line, input int seed, input bit gaps);
        for (int l = 0; l < H; l++) send_line(per_line, l == 0, seed + l * 31, gaps);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 reset frame_ready", frame_ready, 0);
        chk("R8 reset frame_seq", frame_seq, 0);
        chk("R8 reset frame_err", frame_err, 0);
        chk("R8 reset have_frame", have_frame, 0);
        chk("R8 reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        idle(3);

        // R9: valid pixels with no open frame and no start flag are ignored
        send_line(W, 1'b0, 7, 1'b0);
        send_line(W, 1'b0, 9, 1'b1);
        idle(4);
        chk("R9 stray pixels ignored have_frame", have_frame, 0);

        // R1 R4: first good frame with idle gaps
        send_frame(W, 3, 1'b1); n_good_sent++;
        idle(40);
        chk("R4 first frame published", have_frame, 1);

        // R4 R7: irregular lines with correct total, host keeps reading
        send_line(7, 1'b1, 50, 1'b0);
        send_line(9, 1'b0, 60, 1'b0);
        send_line(8, 1'b0, 70, 1'b0);
        send_line(8, 1'b0, 80, 1'b0);
        n_good_sent++;
        idle(20);

        // R6: short frame, then long frame
        send_frame(W - 1, 100, 1'b0);
        idle(20);
        chk("R6 short frame flags error", frame_err, 1);
        send_frame(W + 1, 120, 1'b1);
        idle(20);
        chk("R6 long frame keeps error", frame_err, 1);

        // R6: good frame clears error
        send_frame(W, 140, 1'b0); n_good_sent++;
        idle(10);
        chk("R6 good frame clears error", frame_err, 0);

        // R6: aborted frame followed at once by a good frame
        send_line(W, 1'b1, 160, 1'b0);
        send_line(W, 1'b0, 170, 1'b0);
        send_frame(W, 180, 1'b0); n_good_sent++;
        idle(40);

        // R10: run the sequence counter past its wrap
        for (int f = 0; f < 256; f++) begin
            send_frame(W, f * 5 + 1, 1'b0);
            n_good_sent++;
        end
        idle(80);
        chk("R10 sequence wrap", frame_seq, n_good_sent % (1 << SW));
        chk("R10 have_frame held", have_frame, 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule